// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers of a processor core. Software sees sixteen register indices, but the physical register that an index selects depends on a 5-bit processor mode. The low indices are the same in every mode. The middle group has a second copy that only the fast-interrupt mode uses. The stack and link indices have a copy for each exception mode. Index 15 is not stored here. A read of index 15 returns the current program counter plus a pipeline offset.

There is one combinational read port and one write port. The write port updates storage at the rising clock edge. Each port has its own index and mode inputs, so a core can read or write a bank other than the one its current mode selects. A shared set of context inputs decides whether an access is legal: the current mode, the security-extension-present flag, the non-secure bit, the fast-interrupt restriction bit and the instruction-set flag. When an access is illegal the block raises a per-port unpredictable flag. A flagged write changes no storage, and a flagged read returns zero. A write to index 15 raises its own error flag and changes no storage.

There is no state machine. The decode runs in a fixed order for each port:
- Classify the mode into a bank. The bank is one of user, fast-interrupt, interrupt, supervisor, abort, undefined, monitor or none.
- Apply the legality checks.
- Form the physical address.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low, every physical register is cleared. After reset, reading any index 0..14 in a valid mode returns 0.
- R2: The valid mode codes are 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10110 monitor, 5'b10111 abort, 5'b11011 undefined and 5'b11111 system. An access to index 0..14 with any other code raises the unpredictable flag.
- R3: When sec_ext = 0, mode 5'b10110 is an invalid mode, so any access to index 0..14 in it is unpredictable.
- R4: Indices 0..7 select the same physical register in every valid mode.
- R5: Indices 8..12 have a separate copy for mode 5'b10001 only. Every other valid mode, system mode included, uses the shared copy.
- R6: Indices 13 and 14 have separate copies for the fast-interrupt, interrupt, supervisor, abort, undefined and monitor modes. System mode uses the user copies.
- R7: A read of index 15 never raises rd_unpred. It returns cur_pc + 8 when full_isa = 1 and cur_pc + 4 when full_isa = 0.
- R8: A write to index 15 raises wr_pc_err and leaves wr_unpred low. It updates no storage.
- R9: The core is in secure state when sec_ext = 0, or ns_bit = 0, or cur_mode = 5'b10110. In non-secure state, an access whose mode is 5'b10110 is unpredictable. So is an access whose mode is 5'b10001 while fiq_restrict = 1.
- R10: A write to index 13 is unpredictable when wr_data[1:0] is not 2'b00 and full_isa = 0. With full_isa = 1 the same write is legal.
- R11: A write flagged unpredictable leaves storage unchanged. A read flagged unpredictable returns 0.
- R12: A read reflects storage without delay. A write becomes visible only after the rising clock edge at which wr_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_idx | input | 4 | Read register index |
| rd_mode | input | 5 | Mode whose bank the read uses |
| rd_data | output | DATA_W | Read result |
| rd_unpred | output | 1 | Read access is unpredictable |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_mode | input | 5 | Mode whose bank the write uses |
| wr_data | input | DATA_W | Write value |
| wr_unpred | output | 1 | Write access is unpredictable and is dropped |
| wr_pc_err | output | 1 | Write targeted index 15 and is dropped |
| cur_pc | input | DATA_W | Current program counter |
| cur_mode | input | 5 | Current processor mode |
| full_isa | input | 1 | 1 when executing the full-width instruction set |
| sec_ext | input | 1 | Security extension is present |
| ns_bit | input | 1 | Non-secure bit |
| fiq_restrict | input | 1 | Blocks non-secure access to the fast-interrupt bank |

## Verification
The bench writes distinct values through different modes and reads them back through other modes. A decoder that aliases two banks, or fails to map system mode onto the user bank, returns a wrong value. It gives monitor mode with the security extension removed, non-secure access to the monitor and fast-interrupt banks, and misaligned stack writes in both instruction-set states. A design that let any of these through would either show the dropped value on a later read or leave the flag low. It also reads index 15 under both offsets, writes index 15, and reads a register in the same cycle it is written. These catch a wrong offset, a write that is not blocked, and a read that bypasses storage.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int NUM_IDX     = 16;
    localparam int IDX_W       = $clog2(NUM_IDX);
    localparam int LOW_CNT     = 8;
    localparam int HI_FIRST    = 8;
    localparam int HI_CNT      = 5;
    localparam int SP_IDX      = 13;
    localparam int LR_IDX      = 14;
    localparam int PC_IDX      = 15;
    localparam int SPLR_BANKS  = 7;
    localparam int FIQ_HI_BASE = LOW_CNT + HI_CNT;
    localparam int SPLR_BASE   = FIQ_HI_BASE + HI_CNT;
    localparam int PHYS_CNT    = SPLR_BASE + 2 * SPLR_BANKS;
    localparam int PHYS_W      = $clog2(PHYS_CNT);

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_MON = 5'b10110;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR  = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5,
        BK_MON  = 3'd6,
        BK_NONE = 3'd7
    } bank_e;

    // Mode code to bank; monitor exists only with the security extension.
    function automatic bank_e mode_to_bank(input logic [4:0] m, input logic sec);
        bank_e b;
        unique case (m)
            M_USR, M_SYS: b = BK_USR;
            M_FIQ:        b = BK_FIQ;
            M_IRQ:        b = BK_IRQ;
            M_SVC:        b = BK_SVC;
            M_ABT:        b = BK_ABT;
            M_UND:        b = BK_UND;
            M_MON:        b = sec ? BK_MON : BK_NONE;
            default:      b = BK_NONE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
    import bankreg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [4:0]        mode,
    input  logic [4:0]        cur_mode,
    input  logic              sec_ext,
    input  logic              ns_bit,
    input  logic              fiq_restrict,
    output logic [PHYS_W-1:0] phys,
    output logic              bad_mode,
    output logic              sec_block
);

    bank_e bank;
    logic  secure;

    always_comb begin
        bank     = mode_to_bank(mode, sec_ext);
        bad_mode = (bank == BK_NONE);
    end

    // Secure-state rule and the two banks that non-secure code may not reach
    always_comb begin
        secure    = !sec_ext || !ns_bit || (cur_mode == M_MON);
        sec_block = !secure && ((mode == M_MON) || ((mode == M_FIQ) && fiq_restrict));
    end

    always_comb begin
        phys = '0;
        if (int'(idx) < LOW_CNT) begin
            phys = PHYS_W'(idx);
        end else if (int'(idx) < HI_FIRST + HI_CNT) begin
            if (bank == BK_FIQ)
                phys = PHYS_W'(FIQ_HI_BASE) + PHYS_W'(idx - IDX_W'(HI_FIRST));
            else
                phys = PHYS_W'(idx);
        end else if (int'(idx) == SP_IDX || int'(idx) == LR_IDX) begin
            if (!bad_mode)
                phys = PHYS_W'(SPLR_BASE) + PHYS_W'({bank, (int'(idx) == LR_IDX)});
        end
    end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R12
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_idx,
    input  logic [4:0]        rd_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_unpred,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [4:0]        wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_unpred,
    output logic              wr_pc_err,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [4:0]        cur_mode,
    input  logic              full_isa,
    input  logic              sec_ext,
    input  logic              ns_bit,
    input  logic              fiq_restrict
);

    localparam logic [DATA_W-1:0] PC_OFS_FULL = DATA_W'(8);
    localparam logic [DATA_W-1:0] PC_OFS_NARROW = DATA_W'(4);

    logic [PHYS_W-1:0] rd_phys, wr_phys;
    logic              rd_bad, rd_blk, wr_bad, wr_blk;
    logic [DATA_W-1:0] st_rdata;
    logic              st_we;
    logic              rd_is_pc, wr_is_pc, sp_misalign;

    bankreg_decode u_rd_dec (
        .idx(rd_idx), .mode(rd_mode), .cur_mode(cur_mode), .sec_ext(sec_ext),
        .ns_bit(ns_bit), .fiq_restrict(fiq_restrict),
        .phys(rd_phys), .bad_mode(rd_bad), .sec_block(rd_blk)
    );

    bankreg_decode u_wr_dec (
        .idx(wr_idx), .mode(wr_mode), .cur_mode(cur_mode), .sec_ext(sec_ext),
        .ns_bit(ns_bit), .fiq_restrict(fiq_restrict),
        .phys(wr_phys), .bad_mode(wr_bad), .sec_block(wr_blk)
    );

    bankreg_store #(.DATA_W(DATA_W), .DEPTH(PHYS_CNT)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(wr_phys), .wdata(wr_data),
        .raddr(rd_phys), .rdata(st_rdata)
    );

    // Read path
    always_comb begin
        rd_is_pc  = (int'(rd_idx) == PC_IDX);
        rd_unpred = !rd_is_pc && (rd_bad || rd_blk);
        if (rd_is_pc)
            rd_data = cur_pc + (full_isa ? PC_OFS_FULL : PC_OFS_NARROW);
        else if (rd_unpred)
            rd_data = '0;
        else
            rd_data = st_rdata;
    end

    // Write path
    always_comb begin
        wr_is_pc    = (int'(wr_idx) == PC_IDX);
        sp_misalign = (int'(wr_idx) == SP_IDX) && (wr_data[1:0] != 2'b00) && !full_isa;
        wr_pc_err   = wr_en && wr_is_pc;
        wr_unpred   = wr_en && !wr_is_pc && (wr_bad || wr_blk || sp_misalign);
        st_we       = wr_en && !wr_is_pc && !wr_unpred;
    end

    // R7
    pc_read_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 4'd15) |-> !rd_unpred);

    // R8
    pc_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pc_err |-> !st_we);

    // R11
    unpred_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unpred |-> !st_we);

    // R11
    unpred_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unpred |-> (rd_data == '0));

    // R6
    system_user_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_mode == M_SYS) && (wr_mode == M_USR) && (rd_idx == wr_idx) &&
         (rd_idx != 4'd15) && !rd_unpred && !wr_bad && !wr_blk) |-> (rd_phys == wr_phys));

    // R4
    low_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_idx < 4'd8) && !rd_unpred) |-> (rd_phys == PHYS_W'(rd_idx)));

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

    localparam int CLK_P = 10;
    localparam int DW = 32;

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, MON = 5'b10110, ABT = 5'b10111,
                           UND = 5'b11011, SYS = 5'b11111;

    typedef struct packed {
        logic        wr;
        logic [3:0]  idx;
        logic [4:0]  mode;
        logic [31:0] data;
        logic        unp;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd3,  USR,   32'h33, 1'b0, 32'h0,  4'd4},  // R4
        '{1'b1, 4'd9,  USR,   32'h90, 1'b0, 32'h0,  4'd5},  // R5
        '{1'b1, 4'd9,  FIQ,   32'h91, 1'b0, 32'h0,  4'd5},
        '{1'b1, 4'd13, SVC,   32'hD4, 1'b0, 32'h0,  4'd6},  // R6
        '{1'b1, 4'd13, USR,   32'hD0, 1'b0, 32'h0,  4'd6},
        '{1'b1, 4'd14, IRQ,   32'hE2, 1'b0, 32'h0,  4'd6},
        '{1'b1, 4'd14, SYS,   32'hE0, 1'b0, 32'h0,  4'd6},
        '{1'b1, 4'd5,  MON,   32'h55, 1'b0, 32'h0,  4'd2},  // R2
        '{1'b0, 4'd3,  FIQ,   32'h0,  1'b0, 32'h33, 4'd4},
        '{1'b0, 4'd9,  SYS,   32'h0,  1'b0, 32'h90, 4'd5},
        '{1'b0, 4'd9,  FIQ,   32'h0,  1'b0, 32'h91, 4'd5},
        '{1'b0, 4'd9,  IRQ,   32'h0,  1'b0, 32'h90, 4'd5},
        '{1'b0, 4'd13, SVC,   32'h0,  1'b0, 32'hD4, 4'd6},
        '{1'b0, 4'd13, SYS,   32'h0,  1'b0, 32'hD0, 4'd6},
        '{1'b0, 4'd14, USR,   32'h0,  1'b0, 32'hE0, 4'd6},
        '{1'b0, 4'd14, IRQ,   32'h0,  1'b0, 32'hE2, 4'd6},
        '{1'b0, 4'd13, ABT,   32'h0,  1'b0, 32'h0,  4'd6},
        '{1'b0, 4'd5,  UND,   32'h0,  1'b0, 32'h55, 4'd4},
        '{1'b1, 4'd4,  5'h15, 32'h44, 1'b1, 32'h0,  4'd2},
        '{1'b0, 4'd4,  USR,   32'h0,  1'b0, 32'h0,  4'd11}, // R11
        '{1'b0, 4'd4,  5'h00, 32'h0,  1'b1, 32'h0,  4'd2}
    };

    logic clk = 0, rst_n = 0;
    logic [3:0] rd_idx = 0, wr_idx = 0;
    logic [4:0] rd_mode = USR, wr_mode = USR, cur_mode = USR;
    logic [DW-1:0] rd_data, wr_data = 0, cur_pc = 0;
    logic rd_unpred, wr_en = 0, wr_unpred, wr_pc_err;
    logic full_isa = 1, sec_ext = 1, ns_bit = 0, fiq_restrict = 0;
    logic last_unp, last_pce;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    banked_regfile #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_mode(rd_mode),
        .rd_data(rd_data), .rd_unpred(rd_unpred), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mode(wr_mode), .wr_data(wr_data), .wr_unpred(wr_unpred),
        .wr_pc_err(wr_pc_err), .cur_pc(cur_pc), .cur_mode(cur_mode),
        .full_isa(full_isa), .sec_ext(sec_ext), .ns_bit(ns_bit),
        .fiq_restrict(fiq_restrict)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] i, input logic [4:0] m);
        @(negedge clk);
        rd_idx = i; rd_mode = m;
        #1;
    endtask

    task automatic wr(input logic [3:0] i, input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = i; wr_mode = m; wr_data = d;
        #1;
        last_unp = wr_unpred; last_pce = wr_pc_err;
        @(posedge clk);
        #1 wr_en = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 3);
        rst_n = 1;
        // R1: reset state visible on every stored index
        for (int i = 0; i < 15; i++) begin
            rd(4'(i), USR);
            chk(rd_data == 0 && !rd_unpred, "R1", rd_data, 0);
        end

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                wr(VECS[v].idx, VECS[v].mode, VECS[v].data);
                chk(last_unp == VECS[v].unp, $sformatf("R%0d vec%0d", VECS[v].req, v),
                    32'(last_unp), 32'(VECS[v].unp));
            end else begin
                rd(VECS[v].idx, VECS[v].mode);
                chk(rd_unpred == VECS[v].unp && rd_data == VECS[v].exp,
                    $sformatf("R%0d vec%0d", VECS[v].req, v), rd_data, VECS[v].exp);
            end
        end

        // R7: program counter read offsets
        cur_pc = 32'h1000;
        rd(4'd15, USR);
        chk(rd_data == 32'h1008 && !rd_unpred, "R7", rd_data, 32'h1008);
        full_isa = 0;
        rd(4'd15, 5'h00);
        chk(rd_data == 32'h1004 && !rd_unpred, "R7", rd_data, 32'h1004);
        full_isa = 1;

        // R8: write to index 15 is refused
        wr(4'd15, USR, 32'hDEAD);
        chk(last_pce && !last_unp, "R8", 32'({last_pce, last_unp}), 32'h2);
        rd(4'd15, USR);
        chk(rd_data == 32'h1008, "R8", rd_data, 32'h1008);

        // R3: monitor mode without the security extension
        sec_ext = 0;
        rd(4'd5, MON);
        chk(rd_unpred && rd_data == 0, "R3", rd_data, 0);
        wr(4'd14, MON, 32'hAA);
        chk(last_unp, "R3", 32'(last_unp), 1);
        sec_ext = 1;
        rd(4'd14, MON);
        chk(rd_data == 0 && !rd_unpred, "R3", rd_data, 0);

        // R9: non-secure restrictions
        ns_bit = 1; cur_mode = USR;
        rd(4'd0, MON);
        chk(rd_unpred, "R9", 32'(rd_unpred), 1);
        fiq_restrict = 1;
        rd(4'd9, FIQ);
        chk(rd_unpred && rd_data == 0, "R9", rd_data, 0);
        fiq_restrict = 0;
        rd(4'd9, FIQ);
        chk(!rd_unpred && rd_data == 32'h91, "R9", rd_data, 32'h91);
        cur_mode = MON;
        rd(4'd5, MON);
        chk(!rd_unpred && rd_data == 32'h55, "R9", rd_data, 32'h55);
        ns_bit = 0; cur_mode = USR;

        // R10: misaligned stack write only legal in full-width set
        full_isa = 0;
        wr(4'd13, SVC, 32'h102);
        chk(last_unp, "R10", 32'(last_unp), 1);
        rd(4'd13, SVC);
        chk(rd_data == 32'hD4, "R10", rd_data, 32'hD4);
        wr(4'd14, SVC, 32'h3);
        chk(!last_unp, "R10", 32'(last_unp), 0);
        full_isa = 1;
        wr(4'd13, SVC, 32'h102);
        chk(!last_unp, "R10", 32'(last_unp), 0);
        rd(4'd13, SVC);
        chk(rd_data == 32'h102, "R10", rd_data, 32'h102);

        // R12: write visible only after the edge
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd2; wr_mode = USR; wr_data = 32'hAB;
        rd_idx = 4'd2; rd_mode = USR;
        #1;
        chk(rd_data == 0, "R12", rd_data, 0);
        @(posedge clk);
        #1 wr_en = 0;
        chk(rd_data == 32'hAB, "R12", rd_data, 32'hAB);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule